// File: doc/BRIEF.md
# Set/Clear/Toggle Alias Register Bank

This block holds the 32-bit control and status registers of a USB transceiver control unit. Software reaches it through a simple synchronous register bus, with word accesses only, inside a 4 KiB window. Most writable registers answer at four consecutive word slots. Slot 0 is a plain write. Slot 1 ORs bits in, slot 2 clears bits and slot 3 flips bits. Software can therefore change single bits without first reading the register. A read of any of the four slots returns the register itself.

Bit 31 of the control register is a self-clearing soft reset. When it is raised by a plain write or a set write, the power-down, transmit, receive and control registers return to their defaults. A toggle write raises it only if the bit is 1 after the flip. A clear write never raises it. The other registers keep their contents through a soft reset. An active-low asynchronous reset loads every register with its default.

The block has no bus state machine. Each access completes in the cycle it is presented. The only sequencing is the soft-reset override: in the cycle of the control write, the defaults take priority over the written value.

Top module: `sct_regbank`

## Requirements
- R1: The register slot is byte address bits [11:4] and the operation is bits [3:2]: 0 plain write, 1 set, 2 clear, 3 toggle. Power-down is at 0x00, transmit 0x10, receive 0x20, control 0x30, status 0x40, debug 0x50, debug0-status 0x60, debug1 0x70 and version 0x80. Address bits [1:0] are ignored.
- R2: A set write ORs the write data into the register.
- R3: A clear write clears every register bit whose write-data bit is 1.
- R4: A toggle write XORs the write data into the register.
- R5: A read at the base or at any alias slot of a register returns the register's current value on rd_data. The value is registered and is valid in the cycle after rd_en.
- R6: The asynchronous reset loads these values: power-down 0x001E1C00, transmit 0x10060607, receive 0, control 0xC0200000, status 0, debug 0x7F180000, debug0-status 0, debug1 0x00001000, version 0x04020000.
- R7: A plain write or a set write to control with bit 31 set reloads power-down, transmit, receive and control with their R6 values in place of the written value. Status, debug and debug1 are unchanged. A control write with bit 31 clear stores the data and changes no other register.
- R8: A toggle write to control with data bit 31 set performs the R7 soft reset only when control bit 31 was 0 before the write. Otherwise it only toggles. A clear write to control never performs a soft reset.
- R9: Status is written only at 0x40. Writes to 0x44, 0x48 and 0x4C are ignored, and reads there return 0.
- R10: Version and debug0-status ignore writes. Writes to unlisted addresses are ignored, and reads of them (0x90 to 0xFFC, and the alias slots of version and debug0-status) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address inside the window |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_en |

## Verification
The toggle-triggered soft reset is the hardest case to reach. It fires only when control bit 31 is 0 beforehand, and that bit is 1 after every reset and every soft reset. The stimulus therefore first clears the bit through the clear alias, which also shows that a clear never resets. It then toggles the bit up and checks for a reset, and toggles it back down and checks that no reset occurs. Before each soft reset, power-down and the untouched registers are moved away from their defaults, so that both the reload and the preservation can be seen on reads.

// File: rtl/sct_pkg.sv
package sct_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int NUM_SLOTS = 9;
    localparam int SRST_BIT  = 31;

    localparam int SLOT_PWR  = 0;
    localparam int SLOT_TX   = 1;
    localparam int SLOT_RX   = 2;
    localparam int SLOT_CTRL = 3;
    localparam int SLOT_STAT = 4;
    localparam int SLOT_DBG  = 5;
    localparam int SLOT_DBG0 = 6;
    localparam int SLOT_DBG1 = 7;
    localparam int SLOT_VER  = 8;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SET    = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_TOGGLE = 2'd3
    } alias_op_e;

    function automatic logic [DATA_W-1:0] slot_default(input int slot);
        case (slot)
            SLOT_PWR:  return 32'h001E_1C00;
            SLOT_TX:   return 32'h1006_0607;
            SLOT_CTRL: return 32'hC020_0000;
            SLOT_DBG:  return 32'h7F18_0000;
            SLOT_DBG1: return 32'h0000_1000;
            SLOT_VER:  return 32'h0402_0000;
            default:   return '0;
        endcase
    endfunction

    function automatic bit slot_aliased(input int slot);
        return slot <= SLOT_CTRL || slot == SLOT_DBG || slot == SLOT_DBG1;
    endfunction

    function automatic bit slot_writable(input int slot);
        return slot != SLOT_DBG0 && slot != SLOT_VER;
    endfunction

    function automatic bit slot_soft(input int slot);
        return slot <= SLOT_CTRL;
    endfunction
endpackage

// File: rtl/sct_decode.sv
module sct_decode
    import sct_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int SLOTS = NUM_SLOTS
) (
    input  logic [AW-1:0]    addr,
    output logic [SLOTS-1:0] slot_hit,
    output alias_op_e        op
);
    localparam int SNW = AW - 4;

    logic [SNW-1:0] slot_num;
    logic           unused_lo;

    assign slot_num  = addr[AW-1:4];
    assign op        = alias_op_e'(addr[3:2]);
    assign unused_lo = ^addr[1:0];

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            slot_hit[s] = (slot_num == SNW'(s)) &&
                          (op == OP_WRITE || slot_aliased(s));
        end
    end
endmodule

// File: rtl/sct_reg.sv
module sct_reg
    import sct_pkg::*;
#(
    parameter int            DW       = DATA_W,
    parameter logic [DW-1:0] RST_VAL  = '0,
    parameter bit            WRITABLE = 1'b1,
    parameter bit            SOFT     = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_hit,
    input  alias_op_e     op,
    input  logic [DW-1:0] wdata,
    input  logic          srst,
    output logic [DW-1:0] q
);
    generate
        if (WRITABLE) begin : g_rw
            logic [DW-1:0] q_r;
            assign q = q_r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_r <= RST_VAL;
                end else if (SOFT && srst) begin
                    q_r <= RST_VAL;
                end else if (wr_hit) begin
                    unique case (op)
                        OP_WRITE:  q_r <= wdata;
                        OP_SET:    q_r <= q_r | wdata;
                        OP_CLEAR:  q_r <= q_r & ~wdata;
                        OP_TOGGLE: q_r <= q_r ^ wdata;
                    endcase
                end
            end

            // R2
            p_set_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit && op == OP_SET && !srst) |=> (q_r == ($past(q_r) | $past(wdata))));
            // R3
            p_clear_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit && op == OP_CLEAR && !srst) |=> (q_r == ($past(q_r) & ~$past(wdata))));
            // R4
            p_toggle_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_hit && op == OP_TOGGLE && !srst) |=> (q_r == ($past(q_r) ^ $past(wdata))));
            // R2, R3, R4: no write strobe and no soft reset leaves the value alone
            p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (!wr_hit && !srst) |=> $stable(q_r));
        end else begin : g_ro
            logic unused_ro;
            assign q         = RST_VAL;
            assign unused_ro = ^{clk, rst_n, wr_hit, op, wdata, srst};
        end
    endgenerate
endmodule

// File: rtl/sct_regbank.sv
module sct_regbank
    import sct_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data
);
    logic [NUM_SLOTS-1:0] slot_hit;
    alias_op_e            op;
    logic [DW-1:0]        reg_q [NUM_SLOTS];
    logic                 ctrl_wr;
    logic                 soft_rst;
    logic [DW-1:0]        rd_mux;

    sct_decode #(.AW(AW), .SLOTS(NUM_SLOTS)) u_decode (
        .addr     (addr),
        .slot_hit (slot_hit),
        .op       (op)
    );

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            sct_reg #(
                .DW       (DW),
                .RST_VAL  (DW'(slot_default(s))),
                .WRITABLE (slot_writable(s)),
                .SOFT     (slot_soft(s))
            ) u_reg (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_hit (wr_en && slot_hit[s]),
                .op     (op),
                .wdata  (wr_data),
                .srst   (soft_rst),
                .q      (reg_q[s])
            );
        end
    endgenerate

    // Soft-reset trigger: plain and set fire on data bit; toggle only if bit ends high
    assign ctrl_wr = wr_en && slot_hit[SLOT_CTRL];

    always_comb begin
        unique case (op)
            OP_WRITE, OP_SET: soft_rst = ctrl_wr && wr_data[SRST_BIT];
            OP_TOGGLE:        soft_rst = ctrl_wr && wr_data[SRST_BIT] &&
                                         !reg_q[SLOT_CTRL][SRST_BIT];
            OP_CLEAR:         soft_rst = 1'b0;
        endcase
    end

    always_comb begin
        rd_mux = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (slot_hit[s]) rd_mux = reg_q[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    // R7: soft reset reloads the soft group
    p_srst_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (reg_q[SLOT_PWR] == DW'(slot_default(SLOT_PWR)) &&
                      reg_q[SLOT_RX] == DW'(slot_default(SLOT_RX)) &&
                      reg_q[SLOT_CTRL] == DW'(slot_default(SLOT_CTRL))));
    // R7: registers outside the soft group survive
    p_srst_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ($stable(reg_q[SLOT_DBG]) && $stable(reg_q[SLOT_STAT])));
    // R8: clearing control never disturbs the soft group
    p_clr_no_srst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && op == OP_CLEAR) |=> $stable(reg_q[SLOT_PWR]));
    // R5: alias reads return the base register one cycle later
    p_rd_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && slot_hit[SLOT_DBG]) |=> (rd_data == $past(reg_q[SLOT_DBG])));
    // R10: unimplemented reads return zero
    p_rd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && slot_hit == '0) |=> (rd_data == '0));
endmodule

// File: tb/test_sct_regbank.sv
`timescale 1ns/1ps
module test_sct_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sct_regbank i_sct_regbank (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] a;
        logic [31:0] v;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        // R6 reset values, R1 base layout
        '{1'b1, 12'h000, 32'h001E1C00, 8'd6},
        '{1'b1, 12'h010, 32'h10060607, 8'd6},
        '{1'b1, 12'h020, 32'h00000000, 8'd6},
        '{1'b1, 12'h030, 32'hC0200000, 8'd6},
        '{1'b1, 12'h040, 32'h00000000, 8'd6},
        '{1'b1, 12'h050, 32'h7F180000, 8'd6},
        '{1'b1, 12'h060, 32'h00000000, 8'd6},
        '{1'b1, 12'h070, 32'h00001000, 8'd6},
        '{1'b1, 12'h080, 32'h04020000, 8'd6},
        // R2 set
        '{1'b0, 12'h004, 32'h000000FF, 8'd2},
        '{1'b1, 12'h000, 32'h001E1CFF, 8'd2},
        // R3 clear
        '{1'b0, 12'h008, 32'h001E0000, 8'd3},
        '{1'b1, 12'h000, 32'h00001CFF, 8'd3},
        // R4 toggle
        '{1'b0, 12'h00C, 32'h0000FF00, 8'd4},
        '{1'b1, 12'h000, 32'h0000E3FF, 8'd4},
        // R5 alias reads
        '{1'b1, 12'h004, 32'h0000E3FF, 8'd5},
        '{1'b1, 12'h008, 32'h0000E3FF, 8'd5},
        '{1'b1, 12'h00C, 32'h0000E3FF, 8'd5},
        // R1 debug base and toggle slot read
        '{1'b0, 12'h050, 32'h12345678, 8'd1},
        '{1'b1, 12'h05C, 32'h12345678, 8'd1},
        // R3 debug1 clear
        '{1'b0, 12'h070, 32'hA5A5A5A5, 8'd1},
        '{1'b0, 12'h078, 32'h0000FFFF, 8'd3},
        '{1'b1, 12'h074, 32'hA5A50000, 8'd3},
        // R4 receive toggle
        '{1'b0, 12'h020, 32'h00000055, 8'd1},
        '{1'b0, 12'h02C, 32'h000000FF, 8'd4},
        '{1'b1, 12'h020, 32'h000000AA, 8'd4},
        // R2 transmit set
        '{1'b0, 12'h014, 32'h00000008, 8'd2},
        '{1'b1, 12'h010, 32'h1006060F, 8'd2},
        // R9 status
        '{1'b0, 12'h040, 32'hDEADBEEF, 8'd9},
        '{1'b1, 12'h040, 32'hDEADBEEF, 8'd9},
        '{1'b0, 12'h044, 32'hFFFFFFFF, 8'd9},
        '{1'b0, 12'h048, 32'hFFFFFFFF, 8'd9},
        '{1'b1, 12'h040, 32'hDEADBEEF, 8'd9},
        '{1'b1, 12'h044, 32'h00000000, 8'd9},
        // R10 read-only and unlisted
        '{1'b0, 12'h080, 32'h00000000, 8'd10},
        '{1'b1, 12'h080, 32'h04020000, 8'd10},
        '{1'b0, 12'h060, 32'hFFFFFFFF, 8'd10},
        '{1'b1, 12'h060, 32'h00000000, 8'd10},
        '{1'b0, 12'h064, 32'hFFFFFFFF, 8'd10},
        '{1'b1, 12'h064, 32'h00000000, 8'd10},
        '{1'b0, 12'h090, 32'hFFFFFFFF, 8'd10},
        '{1'b1, 12'h090, 32'h00000000, 8'd10},
        '{1'b1, 12'hFFC, 32'h00000000, 8'd10},
        // R7 control write without bit 31
        '{1'b0, 12'h030, 32'h00000005, 8'd7},
        '{1'b1, 12'h030, 32'h00000005, 8'd7},
        '{1'b1, 12'h000, 32'h0000E3FF, 8'd7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        check("R6 rd_data after reset", rd_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].rd) begin
                bus_read(VEC[i].a, d);
                check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].v);
            end else begin
                bus_write(VEC[i].a, VEC[i].v);
            end
        end

        // R7 plain write with bit 31 triggers the soft reset
        bus_write(12'h030, 32'h80000001);
        expect_reg("R7 pwr reload", 12'h000, 32'h001E1C00);
        expect_reg("R7 tx reload", 12'h010, 32'h10060607);
        expect_reg("R7 rx reload", 12'h020, 32'h00000000);
        expect_reg("R7 ctrl reload", 12'h030, 32'hC0200000);
        expect_reg("R7 status kept", 12'h040, 32'hDEADBEEF);
        expect_reg("R7 debug kept", 12'h050, 32'h12345678);
        expect_reg("R7 debug1 kept", 12'h070, 32'hA5A50000);

        // R8 clear of bit 31 never resets
        bus_write(12'h004, 32'h00000001);
        bus_write(12'h038, 32'h80000000);
        expect_reg("R8 ctrl after clear", 12'h030, 32'h40200000);
        expect_reg("R8 pwr after clear", 12'h000, 32'h001E1C01);

        // R8 toggle 0->1 resets
        bus_write(12'h03C, 32'h80000000);
        expect_reg("R8 ctrl toggle up", 12'h030, 32'hC0200000);
        expect_reg("R8 pwr toggle up", 12'h000, 32'h001E1C00);

        // R8 toggle 1->0 does not reset
        bus_write(12'h004, 32'h00000001);
        bus_write(12'h03C, 32'h80000000);
        expect_reg("R8 ctrl toggle down", 12'h030, 32'h40200000);
        expect_reg("R8 pwr toggle down", 12'h000, 32'h001E1C01);

        // R7 set write with bit 31 resets
        bus_write(12'h034, 32'h80000000);
        expect_reg("R7 ctrl via set", 12'h030, 32'hC0200000);
        expect_reg("R7 pwr via set", 12'h000, 32'h001E1C00);

        // R6 asynchronous reset mid-run
        bus_write(12'h050, 32'h0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_reg("R6 debug after reset", 12'h050, 32'h7F180000);
        expect_reg("R6 status after reset", 12'h040, 32'h00000000);
        expect_reg("R6 debug1 after reset", 12'h070, 32'h00001000);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule